// File: doc/BRIEF.md
# Three-Region Hybrid Final Adder for an Unsigned Multiplier

This block is the last addition step of an N by N unsigned column-compression multiplier. Once the partial-product tree has reduced its columns to two rows of 2N bits each, this adder adds the two rows. The result is the 2N-bit product.

The word is cut into three regions by bit position. The regions follow how late each column arrives from the tree:

- **Low region (N/2 bits).** Its columns arrive in a staggered way, so it is a plain ripple-carry chain with a carry-in of zero.
- **Middle region (5N/4 bits).** Its columns all arrive late, at roughly the same time. It is a carry-select adder of sub-blocks that grow in width. Every sub-block except the lowest forms its sum once with a zero carry. It then derives the "plus one" version with a binary-to-excess-1 incrementer and picks between the two with the incoming carry.
- **Top region (N/4 bits).** It uses the same select scheme, but the sub-block sums are formed with a carry-lookahead unit.

Each region passes its carry-out to the region above. The carry out of the top bit is dropped.

The adder core is combinational. A thin registered shell holds the two rows at the input and the product at the output, so results appear two clock edges after the rows are presented. The shell has an asynchronous active-low reset.

Top module: `hybrid_cpa_top`

## Requirements
- R1: The product output equals (row_a + row_b) modulo 2^(2N) for any pair of row values.
- R2: Rows present at a rising clock edge appear as their sum on the product output after the following rising edge, and not before it (two-edge latency).
- R3: While rst_n is low, the product output is zero after every rising edge. It is still zero after the first rising edge following release.
- R4: The low region (bits 0 to N/2-1) has a carry-in of zero: adding zero to zero gives zero, and adding zero to any value gives that value.
- R5: A carry generated out of bit N/2-1 reaches bit N/2, the lowest bit of the middle region. For example, (2^(N/2) - 1) + 1 = 2^(N/2).
- R6: A carry out of the middle region, from bit N/2 + 5N/4 - 1, reaches the lowest bit of the top region. For example, (2^(N/2+5N/4) - 1) + 1 = 2^(N/2+5N/4).
- R7: The carry out of bit 2N-1 is discarded. For example, all ones plus all ones gives all ones except bit 0.
- R8: A carry entering at bit 0 propagates through all three regions: all ones plus one gives zero.
- R9: A carry crosses every sub-block boundary inside the middle and top regions. For every k from 1 to 2N-1, (2^k - 1) + 1 = 2^k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the input and output registers |
| rst_n | input | 1 | Asynchronous active-low reset that clears the registers |
| row_a | input | 2N | First row left by the partial-product tree |
| row_b | input | 2N | Second row left by the partial-product tree |
| product | output | 2N | Registered sum of the two rows, modulo 2^(2N) |

## Verification
Every sum is due two rising edges after its rows are driven. The rows are first registered at the input, and the sum is then registered at the output. The bench changes the rows on a falling edge, lets two rising edges pass, and reads the product on the next falling edge. In one directed check it also reads the product after only one rising edge and expects the previous sum, which pins the latency at exactly two edges. The reset checks read the product during reset and one edge after release. At that point the output register has loaded the sum of the cleared input registers, which is zero.

// File: rtl/hcpa_pkg.sv
package hcpa_pkg;

  // Sub-block k of a region has width FIRST + k; the last block is clipped
  // so the blocks together cover exactly W bits.
  function automatic int blk_count(input int w, input int first);
    int acc;
    int n;
    acc = 0;
    n   = 0;
    for (int i = 0; i < w; i++) begin
      if (acc < w) begin
        acc = acc + first + i;
        n   = n + 1;
      end
    end
    return n;
  endfunction

  // Lowest bit position of sub-block i
  function automatic int blk_lo(input int first, input int i);
    return i * first + (i * (i - 1)) / 2;
  endfunction

  // Width of sub-block i
  function automatic int blk_w(input int w, input int first, input int i);
    int lo;
    int s;
    lo = blk_lo(first, i);
    s  = first + i;
    return (s < w - lo) ? s : w - lo;
  endfunction

endpackage

// File: rtl/hcpa_rca_chain.sv
module hcpa_rca_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;

  always_comb begin
    c[0] = cin;
    for (int k = 0; k < W; k++) begin
      sum[k]   = a[k] ^ b[k] ^ c[k];
      c[k+1]   = (a[k] & b[k]) | (c[k] & (a[k] ^ b[k]));
    end
  end

  assign cout = c[W];
endmodule

// File: rtl/hcpa_cla_unit.sv
module hcpa_cla_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] p;
  logic [W-1:0] g;
  logic [W:0]   c;
  logic         acc;
  logic         run;

  assign p = a ^ b;
  assign g = a & b;

  // Every carry is a flat OR of generate terms masked by propagate runs.
  always_comb begin
    c[0] = cin;
    acc  = 1'b0;
    run  = 1'b0;
    for (int i = 0; i < W; i++) begin
      acc = g[i];
      run = p[i];
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & g[j]);
        run = run & p[j];
      end
      acc    = acc | (run & cin);
      c[i+1] = acc;
    end
  end

  assign sum  = p ^ c[W-1:0];
  assign cout = c[W];
endmodule

// File: rtl/hcpa_region_block.sv
module hcpa_region_block #(
  parameter int W    = 2,
  parameter int LOOK = 0,  // 0: ripple inner adder, 1: lookahead inner adder
  parameter int SEL  = 1   // 0: carry goes straight in, 1: excess-1 select
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] s0;
  logic         c0;
  logic         inner_cin;

  if (LOOK != 0) begin : g_look
    hcpa_cla_unit #(.W(W)) u_add (
      .a(a), .b(b), .cin(inner_cin), .sum(s0), .cout(c0)
    );
  end else begin : g_ripple
    hcpa_rca_chain #(.W(W)) u_add (
      .a(a), .b(b), .cin(inner_cin), .sum(s0), .cout(c0)
    );
  end

  if (SEL != 0) begin : g_sel
    logic [W-1:0] s1;
    logic         run_c;

    assign inner_cin = 1'b0;

    // binary to excess-1: flip each bit whose lower bits are all ones
    always_comb begin
      run_c = 1'b1;
      for (int k = 0; k < W; k++) begin
        s1[k] = s0[k] ^ run_c;
        run_c = run_c & s0[k];
      end
    end

    assign sum  = cin ? s1 : s0;
    assign cout = c0 | (cin & (&s0));
  end else begin : g_direct
    assign inner_cin = cin;
    assign sum       = s0;
    assign cout      = c0;
  end
endmodule

// File: rtl/hcpa_region_hybrid.sv
module hcpa_region_hybrid #(
  parameter int W     = 20,
  parameter int FIRST = 2,
  parameter int LOOK  = 0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  import hcpa_pkg::*;

  localparam int NB = blk_count(W, FIRST);

  logic [NB:0] cy;

  assign cy[0] = cin;

  for (genvar gi = 0; gi < NB; gi++) begin : g_blk
    localparam int LO = blk_lo(FIRST, gi);
    localparam int BW = blk_w(W, FIRST, gi);

    hcpa_region_block #(
      .W    (BW),
      .LOOK (LOOK),
      .SEL  ((gi > 0) ? 1 : 0)
    ) u_blk (
      .a    (a[LO +: BW]),
      .b    (b[LO +: BW]),
      .cin  (cy[gi]),
      .sum  (sum[LO +: BW]),
      .cout (cy[gi+1])
    );
  end

  assign cout = cy[NB];
endmodule

// File: rtl/hybrid_cpa_top.sv
module hybrid_cpa_top #(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*N-1:0] row_a,
  input  logic [2*N-1:0] row_b,
  output logic [2*N-1:0] product
);
  localparam int PW = 2 * N;
  localparam int W1 = N / 2;
  localparam int W2 = (5 * N) / 4;
  localparam int W3 = PW - W1 - W2;
  localparam int B2 = W1 + W2;

  logic [PW-1:0] a_q;
  logic [PW-1:0] b_q;
  logic [PW-1:0] sum_d;
  logic          c1;
  logic          c2;
  logic          c3;

  // input stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= row_a;
      b_q <= row_b;
    end
  end

  // low region: staggered arrival, plain ripple
  hcpa_rca_chain #(.W(W1)) u_low (
    .a    (a_q[W1-1:0]),
    .b    (b_q[W1-1:0]),
    .cin  (1'b0),
    .sum  (sum_d[W1-1:0]),
    .cout (c1)
  );

  // middle region: ripple sub-blocks with excess-1 select
  hcpa_region_hybrid #(.W(W2), .FIRST(2), .LOOK(0)) u_mid (
    .a    (a_q[B2-1:W1]),
    .b    (b_q[B2-1:W1]),
    .cin  (c1),
    .sum  (sum_d[B2-1:W1]),
    .cout (c2)
  );

  // top region: lookahead sub-blocks with excess-1 select
  hcpa_region_hybrid #(.W(W3), .FIRST(2), .LOOK(1)) u_top (
    .a    (a_q[PW-1:B2]),
    .b    (b_q[PW-1:B2]),
    .cin  (c2),
    .sum  (sum_d[PW-1:B2]),
    .cout (c3)
  );

  // output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
    end else begin
      product <= sum_d;
    end
  end
endmodule

// File: rtl/hybrid_cpa_chk.sv
module hybrid_cpa_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*N-1:0] row_a,
  input logic [2*N-1:0] row_b,
  input logic [2*N-1:0] product,
  input logic [2*N-1:0] a_q,
  input logic [2*N-1:0] b_q,
  input logic           c1,
  input logic           c2,
  input logic           c3
);
  localparam int PW  = 2 * N;
  localparam int W1  = N / 2;
  localparam int W12 = W1 + (5 * N) / 4;

  logic [1:0]    cyc;
  logic [PW-1:0] exp_now;
  logic [W1:0]   lo_sum;
  logic [W12:0]  mid_sum;
  logic [PW:0]   full_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
    end else if (cyc != 2'd3) begin
      cyc <= cyc + 2'd1;
    end
  end

  assign exp_now  = row_a + row_b;
  assign lo_sum   = {1'b0, a_q[W1-1:0]} + {1'b0, b_q[W1-1:0]};
  assign mid_sum  = {1'b0, a_q[W12-1:0]} + {1'b0, b_q[W12-1:0]};
  assign full_sum = {1'b0, a_q} + {1'b0, b_q};

  a_r1_stage_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1) |-> (product == $past(a_q + b_q)))
    else $error("R1: product differs from sum of registered rows");

  a_r2_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (product == $past(exp_now, 2)))
    else $error("R2: product not due two edges after rows");

  a_r3_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (product == '0))
    else $error("R3: product not cleared by reset");

  a_r5_carry_region1: assert property (@(posedge clk) disable iff (!rst_n)
    c1 == lo_sum[W1])
    else $error("R5: low region carry wrong");

  a_r6_carry_region2: assert property (@(posedge clk) disable iff (!rst_n)
    c2 == mid_sum[W12])
    else $error("R6: middle region carry wrong");

  a_r7_top_carry: assert property (@(posedge clk) disable iff (!rst_n)
    c3 == full_sum[PW])
    else $error("R7: top carry inconsistent with full sum");
endmodule

bind hybrid_cpa_top hybrid_cpa_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .row_a   (row_a),
  .row_b   (row_b),
  .product (product),
  .a_q     (a_q),
  .b_q     (b_q),
  .c1      (c1),
  .c2      (c2),
  .c3      (c3)
);

// File: tb/hybrid_cpa_top_test.sv
module hybrid_cpa_top_test;
  localparam int N          = 16;
  localparam int PW         = 2 * N;
  localparam int B1         = N / 2;
  localparam int B2         = N / 2 + (5 * N) / 4;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] ra;
  logic [PW-1:0] rb;
  logic [PW-1:0] prod;
  int            vecs = 0;
  int            bad  = 0;
  bit            done = 1'b0;

  hybrid_cpa_top #(.N(N)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_a   (ra),
    .row_b   (rb),
    .product (prod)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [PW-1:0] ref_sum(input logic [PW-1:0] x, input logic [PW-1:0] y);
    logic [PW:0] t;
    t = {1'b0, x} + {1'b0, y};
    return t[PW-1:0];
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_vec(input string tag, input logic [PW-1:0] x, input logic [PW-1:0] y);
    @(negedge clk);
    ra = x;
    rb = y;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(tag, prod, ref_sum(x, y));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0]   r64;
    logic [PW-1:0] x;
    logic [PW-1:0] y;
    logic [PW-1:0] ones;
    int            seed_dummy;

    seed_dummy = $urandom(32'd20240607);
    ones  = '1;
    rst_n = 1'b0;
    ra    = ones;
    rb    = ones;

    // R3: held in reset with nonzero rows
    repeat (3) @(negedge clk);
    check("R3 during reset", prod, '0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3 first edge after release", prod, '0);
    @(posedge clk);
    @(negedge clk);
    check("R7 ones plus ones after release", prod, ref_sum(ones, ones));

    // R2: exact two-edge latency
    x = 32'h1234_5678;
    y = 32'h0fed_cba9;
    run_vec("R2 first vector", x, y);
    ra = 32'h8000_0001;
    rb = 32'h7fff_ffff;
    @(posedge clk);
    @(negedge clk);
    check("R2 one edge only keeps old sum", prod, ref_sum(x, y));
    @(posedge clk);
    @(negedge clk);
    check("R2 second edge shows new sum", prod, ref_sum(32'h8000_0001, 32'h7fff_ffff));

    // R4: low region carry-in is zero
    run_vec("R4 zero plus zero", '0, '0);
    run_vec("R4 value plus zero", 32'hdead_beef, '0);
    run_vec("R4 zero plus value", '0, 32'h0000_00ff);

    // R5 and R6: region boundary carries
    run_vec("R5 carry into middle region", ones >> (PW - B1), 32'd1);
    run_vec("R5 generate at low top bit", 32'd1 << (B1 - 1), 32'd1 << (B1 - 1));
    run_vec("R6 carry into top region", ones >> (PW - B2), 32'd1);
    run_vec("R6 generate at middle top bit", 32'd1 << (B2 - 1), 32'd1 << (B2 - 1));

    // R7 and R8: top carry dropped, full ripple
    run_vec("R7 ones plus ones", ones, ones);
    run_vec("R7 msb plus msb", 32'h8000_0000, 32'h8000_0000);
    run_vec("R8 ones plus one", ones, 32'd1);

    // R9: every bit and sub-block boundary
    for (int k = 1; k < PW; k++) begin
      run_vec("R9 carry sweep", ones >> (PW - k), 32'd1);
    end

    // R1: constrained random mix, biased towards long carry runs
    for (int i = 0; i < 300; i++) begin
      r64 = {$urandom(), $urandom()};
      x   = r64[PW-1:0];
      case ($urandom() % 4)
        0: y = ~x;
        1: y = ~x ^ (32'd1 << ($urandom() % PW));
        2: y = ~x + 32'd1;
        default: begin
          r64 = {$urandom(), $urandom()};
          y   = r64[PW-1:0];
        end
      endcase
      run_vec("R1 random", x, y);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule